// File: doc/BRIEF.md
# Fractional-Period Time-of-Day Counter

This block keeps a 64-bit nanosecond time-of-day value for a precision time protocol clock. While the timer is enabled, the counter moves forward on every clock by a period given in 32.32 fixed point. The integer nanoseconds come from a field of the control register. The fraction is the addend register, which feeds a 32-bit accumulator. The accumulator's carry adds one extra nanosecond on the cycles where it wraps, so the mean step equals the programmed period.

Software reaches the block over a simple 32-bit register bus. Reads are combinational and qualified by a read strobe, and writes take effect at the clock edge. Software loads the 64-bit counter through a low-word shadow. It shifts the clock's phase with a signed 64-bit offset that is added to the counter in the current-time readout, so the running count is never disturbed. A 64-bit current-time read stays coherent because reading the low word freezes the matching high word. Three pulse channels are held here only as disable and gate bits. A 32-bit prescaler value is stored for the output logic.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the control, counter, offset, addend and prescaler registers read 0, and the pulse control register (0xDC) reads 0x00808080.
- R2: While control bit 2 (enable) is set, each clock adds to the counter the integer period plus the carry-out of a 32-bit accumulator that adds the addend register (0xA0) each clock. After a counter load, the value K clocks later is load + K*period + floor(K*addend / 2^32).
- R3: While the enable bit is clear the counter holds its value, and writes to the counter, offset, addend, prescaler and pulse control registers are ignored.
- R4: A write to the counter low word (0x98) only fills a shadow. A write to the high word (0x9C) loads {written high, shadow low} into the counter and clears the fractional accumulator.
- R5: The current time, with its low word at 0xF0 and high word at 0xF4, is counter plus offset modulo 2^64. A low-word read freezes the matching high word, and later high-word reads return that frozen value.
- R6: The offset low (0xB0) and high (0xB4) words are written independently and read back as written. The offset is treated as two's complement through the modulo-2^64 sum.
- R7: With control bit 15 set in the written value, a new period field is not used until the next addend write. With bit 15 clear, the new period is used from the next clock.
- R8: In the pulse control register, channel i keeps a disable bit at 8*i+7 and a gate bit at 8*i+6, for i = 0..2. All other bits read 0.
- R9: Reads of unmapped addresses return 0, and writes to them change no register.
- R10: The control register (0x80) reads back the clock select (bits 1:0), enable (bit 2), mode (bit 15) and period (bits 25:16). All other bits read 0.
- R11: The prescaler (0xA8) stores and returns a full 32-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high, zero otherwise |

## Verification
A wrong accumulator or period path shows up in the current time only after enough clocks for the carry pattern to differ. The sweeps therefore run with zero, one-quarter and near-one fractions over idle windows as long as 41 clocks, which lets a single missed or extra carry change the result. A broken shadow or freeze path is exposed one read later: a live low-word write, or a high word that keeps counting, gives a value that differs from the count expected at the moment of the low read. Deferred period updates are checked by measuring a 10-clock window before and after the addend write.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;
  localparam int PER_W  = 10;
  localparam int CSEL_W = 2;

  localparam int EN_BIT    = 2;
  localparam int MODE_BIT  = 15;
  localparam int PER_LSB   = 16;
  localparam int PDIS_BIT  = 7;
  localparam int PGATE_BIT = 6;

  localparam logic [ADDR_W-1:0] ADR_CTRL    = 8'h80;
  localparam logic [ADDR_W-1:0] ADR_CNT_LO  = 8'h98;
  localparam logic [ADDR_W-1:0] ADR_CNT_HI  = 8'h9C;
  localparam logic [ADDR_W-1:0] ADR_ADDEND  = 8'hA0;
  localparam logic [ADDR_W-1:0] ADR_PRSC    = 8'hA8;
  localparam logic [ADDR_W-1:0] ADR_OFF_LO  = 8'hB0;
  localparam logic [ADDR_W-1:0] ADR_OFF_HI  = 8'hB4;
  localparam logic [ADDR_W-1:0] ADR_PULSE   = 8'hDC;
  localparam logic [ADDR_W-1:0] ADR_TIME_LO = 8'hF0;
  localparam logic [ADDR_W-1:0] ADR_TIME_HI = 8'hF4;

  typedef struct packed {
    logic [PER_W-1:0]  per;
    logic              mode;
    logic              en;
    logic [CSEL_W-1:0] csel;
  } ctrl_t;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_CNT_LO, SEL_CNT_HI, SEL_ADDEND, SEL_PRSC,
    SEL_OFF_LO, SEL_OFF_HI, SEL_PULSE, SEL_TIME_LO, SEL_TIME_HI
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      ADR_CTRL:    s = SEL_CTRL;
      ADR_CNT_LO:  s = SEL_CNT_LO;
      ADR_CNT_HI:  s = SEL_CNT_HI;
      ADR_ADDEND:  s = SEL_ADDEND;
      ADR_PRSC:    s = SEL_PRSC;
      ADR_OFF_LO:  s = SEL_OFF_LO;
      ADR_OFF_HI:  s = SEL_OFF_HI;
      ADR_PULSE:   s = SEL_PULSE;
      ADR_TIME_LO: s = SEL_TIME_LO;
      ADR_TIME_HI: s = SEL_TIME_HI;
      default:     s = SEL_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/ptp_tod_regs.sv
module ptp_tod_regs
  import ptp_tod_pkg::*;
#(
  parameter int NUM_PULSE = 3,
  parameter int FRAC_W    = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [BUS_W-1:0]       wdata,
  output ctrl_t                  ctrl_q,
  output logic [PER_W-1:0]       per_act_q,
  output logic [FRAC_W-1:0]      addend_q,
  output logic [BUS_W-1:0]       prsc_q,
  output logic [2*BUS_W-1:0]     offset_q,
  output logic [NUM_PULSE-1:0]   pdis_q,
  output logic [NUM_PULSE-1:0]   pgate_q,
  output logic                   cnt_load,
  output logic [2*BUS_W-1:0]     cnt_load_val
);
  localparam int CNT_W = 2 * BUS_W;

  reg_sel_e           sel;
  logic               tdom_we;
  ctrl_t              ctrl_d;
  logic [PER_W-1:0]   per_act_d;
  logic [FRAC_W-1:0]  addend_d;
  logic [BUS_W-1:0]   prsc_d;
  logic [CNT_W-1:0]   offset_d;
  logic [BUS_W-1:0]   shadow_q, shadow_d;
  logic               pulse_we;

  assign sel      = decode_addr(addr);
  // timer-domain registers only accept writes while the timer runs
  assign tdom_we  = wr_en && ctrl_q.en;
  assign pulse_we = tdom_we && (sel == SEL_PULSE);

  assign cnt_load     = tdom_we && (sel == SEL_CNT_HI);
  assign cnt_load_val = {wdata, shadow_q};

  always_comb begin
    ctrl_d    = ctrl_q;
    per_act_d = per_act_q;
    addend_d  = addend_q;
    prsc_d    = prsc_q;
    offset_d  = offset_q;
    shadow_d  = shadow_q;
    if (wr_en && sel == SEL_CTRL) begin
      ctrl_d.csel = wdata[CSEL_W-1:0];
      ctrl_d.en   = wdata[EN_BIT];
      ctrl_d.mode = wdata[MODE_BIT];
      ctrl_d.per  = wdata[PER_LSB +: PER_W];
      if (!wdata[MODE_BIT]) per_act_d = wdata[PER_LSB +: PER_W];
    end
    if (tdom_we) begin
      case (sel)
        SEL_ADDEND: begin
          addend_d  = wdata[FRAC_W-1:0];
          per_act_d = ctrl_q.per;
        end
        SEL_PRSC:   prsc_d = wdata;
        SEL_OFF_LO: offset_d[BUS_W-1:0] = wdata;
        SEL_OFF_HI: offset_d[CNT_W-1:BUS_W] = wdata;
        SEL_CNT_LO: shadow_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      per_act_q <= '0;
      addend_q  <= '0;
      prsc_q    <= '0;
      offset_q  <= '0;
      shadow_q  <= '0;
    end else begin
      ctrl_q    <= ctrl_d;
      per_act_q <= per_act_d;
      addend_q  <= addend_d;
      prsc_q    <= prsc_d;
      offset_q  <= offset_d;
      shadow_q  <= shadow_d;
    end
  end

  for (genvar ch = 0; ch < NUM_PULSE; ch++) begin : g_pulse
    logic dis_q, dis_d, gate_q, gate_d;
    always_comb begin
      dis_d  = dis_q;
      gate_d = gate_q;
      if (pulse_we) begin
        dis_d  = wdata[8*ch + PDIS_BIT];
        gate_d = wdata[8*ch + PGATE_BIT];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dis_q  <= 1'b1;
        gate_q <= 1'b0;
      end else begin
        dis_q  <= dis_d;
        gate_q <= gate_d;
      end
    end
    assign pdis_q[ch]  = dis_q;
    assign pgate_q[ch] = gate_q;
  end
endmodule

// File: rtl/ptp_tod_accum.sv
module ptp_tod_accum #(
  parameter int CNT_W  = 64,
  parameter int INT_W  = 10,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_val,
  input  logic [INT_W-1:0]  per_int,
  input  logic [FRAC_W-1:0] addend,
  output logic [CNT_W-1:0]  cnt_q
);
  logic [FRAC_W-1:0] frac_q, frac_d, frac_sum;
  logic              carry;
  logic [CNT_W-1:0]  cnt_d;

  always_comb begin
    {carry, frac_sum} = {1'b0, frac_q} + {1'b0, addend};
    cnt_d  = cnt_q;
    frac_d = frac_q;
    if (load) begin
      cnt_d  = load_val;
      frac_d = '0;
    end else if (step_en) begin
      cnt_d  = cnt_q + CNT_W'(per_int) + CNT_W'(carry);
      frac_d = frac_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      frac_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      frac_q <= frac_d;
    end
  end
endmodule

// File: rtl/ptp_tod_readout.sv
module ptp_tod_readout #(
  parameter int CNT_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lat_en,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [CNT_W-1:0]   offset,
  output logic [CNT_W/2-1:0] time_lo,
  output logic [CNT_W/2-1:0] time_hi_q
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] now;
  logic [HALF-1:0]  hi_d;

  assign now     = cnt + offset;
  assign time_lo = now[HALF-1:0];

  always_comb begin
    hi_d = time_hi_q;
    if (lat_en) hi_d = now[CNT_W-1:HALF];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_hi_q <= '0;
    else        time_hi_q <= hi_d;
  end
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int NUM_PULSE = 3,
  parameter int FRAC_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata
);
  localparam int CNT_W = 2 * BUS_W;

  logic [1:0]           rst_pipe;
  logic                 rst_sync_n;
  ctrl_t                ctrl_q;
  logic [PER_W-1:0]     per_act;
  logic [FRAC_W-1:0]    addend;
  logic [BUS_W-1:0]     prsc;
  logic [CNT_W-1:0]     offset;
  logic [NUM_PULSE-1:0] pdis, pgate;
  logic                 cnt_load;
  logic [CNT_W-1:0]     cnt_load_val;
  logic [CNT_W-1:0]     count;
  logic [BUS_W-1:0]     time_lo, time_hi;
  logic                 lat_en;
  reg_sel_e             rsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  ptp_tod_regs #(.NUM_PULSE(NUM_PULSE), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .ctrl_q(ctrl_q), .per_act_q(per_act),
    .addend_q(addend), .prsc_q(prsc), .offset_q(offset),
    .pdis_q(pdis), .pgate_q(pgate), .cnt_load(cnt_load),
    .cnt_load_val(cnt_load_val)
  );

  ptp_tod_accum #(.CNT_W(CNT_W), .INT_W(PER_W), .FRAC_W(FRAC_W)) u_accum (
    .clk(clk), .rst_n(rst_sync_n), .step_en(ctrl_q.en), .load(cnt_load),
    .load_val(cnt_load_val), .per_int(per_act), .addend(addend),
    .cnt_q(count)
  );

  assign rsel   = decode_addr(bus_addr);
  assign lat_en = bus_rd && (rsel == SEL_TIME_LO);

  ptp_tod_readout #(.CNT_W(CNT_W)) u_readout (
    .clk(clk), .rst_n(rst_sync_n), .lat_en(lat_en), .cnt(count),
    .offset(offset), .time_lo(time_lo), .time_hi_q(time_hi)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (rsel)
        SEL_CTRL: begin
          bus_rdata[CSEL_W-1:0]        = ctrl_q.csel;
          bus_rdata[EN_BIT]            = ctrl_q.en;
          bus_rdata[MODE_BIT]          = ctrl_q.mode;
          bus_rdata[PER_LSB +: PER_W]  = ctrl_q.per;
        end
        SEL_CNT_LO:  bus_rdata = count[BUS_W-1:0];
        SEL_CNT_HI:  bus_rdata = count[CNT_W-1:BUS_W];
        SEL_ADDEND:  bus_rdata[FRAC_W-1:0] = addend;
        SEL_PRSC:    bus_rdata = prsc;
        SEL_OFF_LO:  bus_rdata = offset[BUS_W-1:0];
        SEL_OFF_HI:  bus_rdata = offset[CNT_W-1:BUS_W];
        SEL_PULSE: begin
          for (int ch = 0; ch < NUM_PULSE; ch++) begin
            bus_rdata[8*ch + PDIS_BIT]  = pdis[ch];
            bus_rdata[8*ch + PGATE_BIT] = pgate[ch];
          end
        end
        SEL_TIME_LO: bus_rdata = time_lo;
        SEL_TIME_HI: bus_rdata = time_hi;
        default:     bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ptp_tod_checker.sv
module ptp_tod_checker
  import ptp_tod_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wmode,
  input logic              en,
  input logic              load,
  input logic [CNT_W-1:0]  load_val,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  offset,
  input logic [PER_W-1:0]  per_act,
  input logic [CNT_W/2-1:0] time_hi
);
  localparam int HALF = CNT_W / 2;
  logic [CNT_W-1:0] sum_now;
  reg_sel_e         sel;
  assign sum_now = count + offset;
  assign sel     = decode_addr(bus_addr);

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val)); // R4

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(count)); // R3

  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> ((count - $past(count)) == CNT_W'($past(per_act))) ||
                      ((count - $past(count)) == CNT_W'($past(per_act)) + 1)); // R2

  AST_TIME_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel == SEL_TIME_LO) |=> time_hi == $past(sum_now[CNT_W-1:HALF])); // R5

  AST_PERIOD_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_CTRL && wmode) |=> $stable(per_act)); // R7
endmodule

bind ptp_tod_counter ptp_tod_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .wmode(bus_wdata[ptp_tod_pkg::MODE_BIT]),
  .en(ctrl_q.en), .load(cnt_load), .load_val(cnt_load_val),
  .count(count), .offset(offset), .per_act(per_act), .time_hi(time_hi)
);

// File: tb/tb_ptp_tod_counter.sv
module tb_ptp_tod_counter;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h80, A_CLO = 8'h98, A_CHI = 8'h9C,
    A_ADD = 8'hA0, A_PRS = 8'hA8, A_OLO = 8'hB0, A_OHI = 8'hB4,
    A_PUL = 8'hDC, A_TLO = 8'hF0, A_THI = 8'hF4;
  localparam logic [31:0] EN = 32'h4, MODE = 32'h8000;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_wr, bus_rd;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  ptp_tod_counter dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic load_cnt(input logic [63:0] x);
    wr(A_CLO, x[31:0]);
    wr(A_CHI, x[63:32]);
  endtask

  task automatic read_time(output logic [63:0] t);
    logic [31:0] lo, hi;
    rd(A_TLO, lo);
    rd(A_THI, hi);
    t = {hi, lo};
  endtask

  task automatic run_cfg(input string tag, input int unsigned per, input logic [31:0] add,
                         input logic [63:0] x, input logic [63:0] off, input int k);
    logic [63:0] t, exp;
    longint unsigned k64;
    wr(A_CTRL, EN | (per << 16));
    wr(A_ADD, add);
    wr(A_OLO, off[31:0]);
    wr(A_OHI, off[63:32]);
    load_cnt(x);
    idle(k);
    read_time(t);
    k64 = longint'(k);
    exp = x + k64 * per + ((k64 * add) >> 32) + off;
    chk(tag, t, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v1;
    logic [63:0] t;
    int unsigned pers[3] = '{1, 7, 1023};
    logic [31:0] adds[3] = '{32'h0, 32'h4000_0000, 32'hFFFF_FFFF};
    int ks[3] = '{0, 3, 41};
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    @(negedge clk);
    idle(4);
    rst_n = 1'b1;
    idle(3);

    // R1 reset values
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_CLO, d);  chk("R1 cnt_lo", d, 0);
    rd(A_CHI, d);  chk("R1 cnt_hi", d, 0);
    rd(A_ADD, d);  chk("R1 addend", d, 0);
    rd(A_PRS, d);  chk("R1 prsc", d, 0);
    rd(A_OLO, d);  chk("R1 off_lo", d, 0);
    rd(A_OHI, d);  chk("R1 off_hi", d, 0);
    rd(A_PUL, d);  chk("R1 pulse", d, 32'h0080_8080);
    read_time(t);  chk("R1 time", t, 0);

    // R2 sweep over integer period, fraction and elapsed clocks
    foreach (pers[i]) foreach (adds[j]) foreach (ks[m])
      run_cfg("R2 sweep", pers[i], adds[j], 64'h0000_0001_FFFF_FF00, 64'h0, ks[m]);

    // R5 R6 offset applied, including negative
    run_cfg("R5 neg offset", 3, 32'h8000_0001, 64'h0000_0010_0000_0020, -64'sd100, 17);
    run_cfg("R6 big offset", 2, 32'h0, 64'h0000_0000_FFFF_FFF0, 64'h0000_0001_0000_0000, 9);
    rd(A_OLO, d); chk("R6 off_lo readback", d, 32'h0);
    rd(A_OHI, d); chk("R6 off_hi readback", d, 32'h1);

    // R5 high word frozen at low read
    run_cfg("R5 setup", 1, 32'h0, 64'h0000_0003_FFFF_FFFE, 64'h0, 0);
    load_cnt(64'h0000_0003_FFFF_FFFE);
    rd(A_TLO, d); chk("R5 lo", d, 32'hFFFF_FFFE);
    idle(5);
    rd(A_THI, d); chk("R5 frozen hi", d, 32'h3);
    rd(A_CHI, d); chk("R5 live hi moved", d, 32'h4);

    // R4 shadow: period 0, fraction 0 keeps counter still
    run_cfg("R4 setup", 0, 32'h0, 64'h0000_0005_0000_0007, 64'h0, 2);
    wr(A_CLO, 32'h0000_1111);
    idle(2);
    rd(A_CLO, d); chk("R4 low write only shadowed", d, 32'h7);
    wr(A_CHI, 32'h22);
    rd(A_CLO, d); chk("R4 load lo", d, 32'h1111);
    rd(A_CHI, d); chk("R4 load hi", d, 32'h22);

    // R7 deferred period update
    run_cfg("R7 base", 4, 32'h0, 64'h0, 64'h0, 10);
    wr(A_CTRL, EN | MODE | (32'd9 << 16));
    rd(A_CTRL, d); chk("R10 ctrl mode readback", d, 32'h0009_8004);
    load_cnt(64'h0);
    idle(10);
    rd(A_CLO, d); chk("R7 old period until addend", d, 32'd40);
    wr(A_ADD, 32'h0);
    load_cnt(64'h0);
    idle(10);
    rd(A_CLO, d); chk("R7 new period after addend", d, 32'd90);

    // R11 prescaler, R8 pulse bits (enabled)
    wr(A_PRS, 32'hA5C3_0F12);
    rd(A_PRS, d); chk("R11 prsc", d, 32'hA5C3_0F12);
    wr(A_PUL, 32'hFFFF_FFFF);
    rd(A_PUL, d); chk("R8 pulse all", d, 32'h00C0_C0C0);
    wr(A_PUL, 32'h0000_0040);
    rd(A_PUL, d); chk("R8 pulse ch0 gate", d, 32'h0000_0040);

    // R9 unmapped
    rd(8'h84, d); chk("R9 unmapped read", d, 0);
    wr(A_ADD, 32'h1234_5678);
    wr(8'hA4, 32'hFFFF_FFFF);
    wr(8'h84, 32'hFFFF_FFFF);
    rd(8'hA4, d); chk("R9 unmapped after write", d, 0);
    rd(A_ADD, d); chk("R9 addend untouched", d, 32'h1234_5678);
    rd(A_CTRL, d); chk("R9 ctrl untouched", d, 32'h0009_8004);

    // R3 disabled timer
    wr(A_CTRL, 32'h0004_0000);
    rd(A_CLO, v1);
    idle(6);
    rd(A_CLO, d); chk("R3 counter holds", d, v1);
    load_cnt(64'h0000_00AB_0000_00CD);
    rd(A_CLO, d); chk("R3 load ignored", d, v1);
    wr(A_PRS, 32'h0);
    rd(A_PRS, d); chk("R3 prsc ignored", d, 32'hA5C3_0F12);
    wr(A_ADD, 32'h0);
    rd(A_ADD, d); chk("R3 addend ignored", d, 32'h1234_5678);
    wr(A_OLO, 32'h99);
    rd(A_OLO, d); chk("R3 offset ignored", d, 32'h0);
    wr(A_PUL, 32'h0);
    rd(A_PUL, d); chk("R3 pulse ignored", d, 32'h0000_0040);

    // R10 control field mask
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); chk("R10 ctrl mask", d, 32'h03FF_8007);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule